// File: doc/BRIEF.md
# External Static Memory Bus Cycle Controller

This block turns single requests from an internal requester into read or write bus cycles on an asynchronous external static-memory bus. The requester presents an address, write data, per-byte enables, a direction bit and a chip-select index, and holds its request valid until `busy` rises. The block then drives one active-low chip select, an active-low output-enable strobe, a common active-low write strobe and one active-low strobe per byte lane. It finishes with a one-cycle `done` pulse, and for reads the captured word is on `rdata`.

Each chip select has its own settings, applied as static inputs. These are a wait-state count, a flag that starts the read strobe together with the chip select, and a flag that switches the byte-lane strobes from byte-select use to byte-write use. One chip-select index, chosen by parameter, can also run a slow peripheral cycle. In that cycle the address appears one clock before the chip select falls, the wait-state count is fixed, and address and data stay valid for one clock after the chip select rises. An external bus master can ask for the bus. While the bus is granted, every address, data and control output is released, and internal requests wait.

Top module: `smc_bus_ctrl`

## Requirements
- R1: After reset all chip selects, the output-enable strobe, the write strobe and all lane strobes are high, `busy`, `done`, `ext_gnt` and `data_drive` are 0, and `bus_drive` is 1.
- R2: A request accepted at a clock edge raises `busy` in the next cycle, counted as cycle 1. A normal access (not slow) holds its chip select low from cycle 1 for 3+W cycles, where W is the wait-state count. `done` is high for exactly one cycle, in cycle 4+W, and `busy` is still high in that cycle.
- R3: The wait-state count of the selected chip select is a 3-bit value from 0 to 7. Each unit adds exactly one cycle to the strobe-low time, to the chip-select time and to the `done` delay.
- R4: On a read in standard mode, `mem_oe_n` is low for 1+W cycles, starting in cycle 2. In early mode it goes low in cycle 1 together with the chip select and stays low for 2+W cycles. Writes never lower `mem_oe_n`.
- R5: In byte-select mode (`cfg_bytewr` bit = 0), the strobe for lane i (bit i of `mem_lane_n`, which carries data bits 8i+7..8i) is low for the full chip-select time when byte enable i is set, on reads and writes alike. On writes `mem_we_n` is low for 1+W cycles, starting in cycle 2.
- R6: In byte-write mode (`cfg_bytewr` bit = 1), `mem_we_n` stays high. On a write, the strobe for lane i is low for 1+W cycles, starting in cycle 2, when byte enable i is set. On a read, all lane strobes stay high.
- R7: No read, write or lane strobe is low unless some chip select is low.
- R8: `rdata` takes the `mem_din` value present in the last strobe-low cycle of a read. It is valid when `done` pulses and keeps that value until the next read.
- R9: On a write, `data_drive` is high and `mem_dout` equals the request's write data from cycle 1 until one cycle after the write strobe rises. Reads never raise `data_drive`.
- R10: When `cfg_slow_en` is 1 and the index is SLOW_CS, the access is a slow cycle. The address is valid with all chip selects high in cycle 1. The chip select is low from cycle 2 for 5 cycles, because the wait-state count is forced to 2. Address and write data stay driven in cycle 7 with the chip select high, and `done` pulses in cycle 8.
- R11: With `ext_req` high and the controller idle (no access, no `done` cycle, no request valid), `ext_gnt` rises at the next edge, `bus_drive` drops to 0 and `data_drive` is 0. No grant is given while an access is in progress. After `ext_req` falls, `ext_gnt` clears and `bus_drive` returns to 1 at the next edge.
- R12: A request made while the bus is granted leaves `busy` low and all chip selects high. It starts only after the grant is removed.
- R13: At most one chip select is low at any time, and it is the one whose index was requested. `mem_addr` equals the requested address throughout the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid, held until busy is seen |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | CS_W | Chip-select index |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | LANES | Byte enables, bit i = data bits 8i+7..8i |
| busy | output | 1 | Access in progress, through the done cycle |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Captured read data |
| cfg_ws | input | NUM_CS*WS_W | Wait states, field k belongs to chip select k |
| cfg_early | input | NUM_CS | Early read strobe mode per chip select |
| cfg_bytewr | input | NUM_CS | Byte-write lane mode per chip select |
| cfg_slow_en | input | 1 | Enables slow peripheral cycles on SLOW_CS |
| ext_req | input | 1 | External master bus request |
| ext_gnt | output | 1 | Bus granted to the external master |
| mem_addr | output | ADDR_W | External address |
| mem_dout | output | DATA_W | External write data |
| mem_din | input | DATA_W | External read data |
| data_drive | output | 1 | Write data drive enable |
| bus_drive | output | 1 | Address and control drive enable |
| mem_cs_n | output | NUM_CS | Active-low chip selects |
| mem_oe_n | output | 1 | Active-low read strobe |
| mem_we_n | output | 1 | Active-low common write strobe |
| mem_lane_n | output | LANES | Active-low byte-lane strobes |

## Verification
Every timed result counts from the first cycle in which `busy` is high, which is one edge after the request is taken. The `done` pulse is due in cycle 4+W, or in cycle 8 for a slow cycle, and the captured read word is checked in that same cycle. The strobe-low times are 1+W or 2+W cycles, the chip-select time is 3+W cycles, and the data-drive time is 3+W or 7 cycles. The bench works these numbers out from the settings in force when it issues the request and queues them. A monitor sampling at the falling clock edge counts the low cycles of every pin and compares the counts and the due cycle when `done` appears. Grant and release are checked one edge after `ext_req` changes.

// File: rtl/smc_pkg.sv
package smc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_ADDR   = 3'd1,
      ST_SETUP  = 3'd2,
      ST_STROBE = 3'd3,
      ST_HOLD   = 3'd4,
      ST_POST   = 3'd5,
      ST_GRANT  = 3'd6
   } smc_state_e;

   typedef struct packed {
      logic early;
      logic bytewr;
      logic slow;
   } smc_mode_t;

endpackage

// File: rtl/smc_cfg_sel.sv
module smc_cfg_sel
   import smc_pkg::*;
#(
   parameter int NUM_CS  = 4,
   parameter int WS_W    = 3,
   parameter int SLOW_CS = 3,
   localparam int CS_W   = $clog2(NUM_CS)
) (
   input  logic [NUM_CS*WS_W-1:0] cfg_ws,
   input  logic [NUM_CS-1:0]      cfg_early,
   input  logic [NUM_CS-1:0]      cfg_bytewr,
   input  logic                   cfg_slow_en,
   input  logic [CS_W-1:0]        sel_cs,
   output logic [WS_W-1:0]        sel_ws,
   output smc_mode_t              sel_mode
);

   logic [WS_W-1:0] ws_tab [NUM_CS];

   for (genvar g = 0; g < NUM_CS; g++) begin : g_unpack
      assign ws_tab[g] = cfg_ws[g*WS_W +: WS_W];
   end

   assign sel_ws          = ws_tab[sel_cs];
   assign sel_mode.early  = cfg_early[sel_cs];
   assign sel_mode.bytewr = cfg_bytewr[sel_cs];
   assign sel_mode.slow   = cfg_slow_en && (sel_cs == CS_W'(SLOW_CS));

endmodule

// File: rtl/smc_seq.sv
module smc_seq
   import smc_pkg::*;
#(
   parameter int ADDR_W  = 20,
   parameter int DATA_W  = 16,
   parameter int NUM_CS  = 4,
   parameter int WS_W    = 3,
   parameter int SLOW_WS = 2,
   localparam int CS_W   = $clog2(NUM_CS),
   localparam int LANES  = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [CS_W-1:0]   req_cs,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [LANES-1:0]  req_be,
   input  logic [WS_W-1:0]   sel_ws,
   input  smc_mode_t         sel_mode,
   input  logic              ext_req,
   output smc_state_e        state,
   output logic              last_strobe,
   output logic              lat_write,
   output logic [CS_W-1:0]   lat_cs,
   output logic [ADDR_W-1:0] lat_addr,
   output logic [DATA_W-1:0] lat_wdata,
   output logic [LANES-1:0]  lat_be,
   output smc_mode_t         lat_mode,
   output logic              busy,
   output logic              done,
   output logic              gnt
);

   smc_state_e      nxt;
   logic [WS_W-1:0] lat_ws;
   logic [WS_W-1:0] cnt;
   logic            accept;

   assign accept      = (state == ST_IDLE) && !done && req_valid;
   assign last_strobe = (state == ST_STROBE) && (cnt == '0);
   assign busy        = ((state != ST_IDLE) && (state != ST_GRANT)) || done;
   assign gnt         = (state == ST_GRANT);

   always_comb begin
      nxt = state;
      case (state)
         ST_IDLE:   if (accept)                    nxt = sel_mode.slow ? ST_ADDR : ST_SETUP;
                    else if (!done && ext_req)     nxt = ST_GRANT;
         ST_ADDR:   nxt = ST_SETUP;
         ST_SETUP:  nxt = ST_STROBE;
         ST_STROBE: if (cnt == '0)                 nxt = ST_HOLD;
         ST_HOLD:   nxt = lat_mode.slow ? ST_POST : ST_IDLE;
         ST_POST:   nxt = ST_IDLE;
         ST_GRANT:  if (!ext_req)                  nxt = ST_IDLE;
         default:   nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         done  <= 1'b0;
         cnt   <= '0;
      end else begin
         state <= nxt;
         done  <= ((state == ST_HOLD) && !lat_mode.slow) || (state == ST_POST);
         if (state == ST_SETUP)
            cnt <= lat_ws;
         else if ((state == ST_STROBE) && (cnt != '0))
            cnt <= cnt - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_write <= 1'b0;
         lat_cs    <= '0;
         lat_addr  <= '0;
         lat_wdata <= '0;
         lat_be    <= '0;
         lat_mode  <= '0;
         lat_ws    <= '0;
      end else if (accept) begin
         lat_write <= req_write;
         lat_cs    <= req_cs;
         lat_addr  <= req_addr;
         lat_wdata <= req_wdata;
         lat_be    <= req_be;
         lat_mode  <= sel_mode;
         lat_ws    <= sel_mode.slow ? WS_W'(SLOW_WS) : sel_ws;
      end
   end

   // R3: the strobe countdown never exceeds the latched wait-state count
   p_ws_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_STROBE) |-> (cnt <= lat_ws));

   // R2: completion is a single-cycle pulse
   p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R11: a grant only follows a cycle with no access in progress
   p_gnt_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gnt) |-> $past(!busy && !req_valid));

   // R12: no access starts while the bus is granted away
   p_stall_r12: assert property (@(posedge clk) disable iff (!rst_n)
      gnt |=> !busy);

endmodule

// File: rtl/smc_pins.sv
module smc_pins
   import smc_pkg::*;
#(
   parameter int ADDR_W  = 20,
   parameter int DATA_W  = 16,
   parameter int NUM_CS  = 4,
   localparam int CS_W   = $clog2(NUM_CS),
   localparam int LANES  = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  smc_state_e        state,
   input  logic              last_strobe,
   input  logic              lat_write,
   input  logic [CS_W-1:0]   lat_cs,
   input  logic [ADDR_W-1:0] lat_addr,
   input  logic [DATA_W-1:0] lat_wdata,
   input  logic [LANES-1:0]  lat_be,
   input  smc_mode_t         lat_mode,
   input  logic [DATA_W-1:0] mem_din,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dout,
   output logic              data_drive,
   output logic              bus_drive,
   output logic [NUM_CS-1:0] mem_cs_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [LANES-1:0]  mem_lane_n,
   output logic [DATA_W-1:0] rdata
);

   logic active, cs_low, strobe;

   assign active = (state == ST_ADDR) || (state == ST_SETUP) || (state == ST_STROBE) ||
                   (state == ST_HOLD) || (state == ST_POST);
   assign cs_low = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
   assign strobe = (state == ST_STROBE);

   for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
      assign mem_cs_n[g] = !(cs_low && (lat_cs == CS_W'(g)));
   end

   assign mem_oe_n = !(!lat_write && (strobe || ((state == ST_SETUP) && lat_mode.early)));
   assign mem_we_n = !(lat_write && !lat_mode.bytewr && strobe);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign mem_lane_n[i] = lat_mode.bytewr ? !(lat_write && lat_be[i] && strobe)
                                             : !(lat_be[i] && cs_low);
   end

   assign mem_addr   = lat_addr;
   assign mem_dout   = lat_wdata;
   assign data_drive = active && lat_write;
   assign bus_drive  = (state != ST_GRANT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata <= '0;
      else if (last_strobe && !lat_write)
         rdata <= mem_din;
   end

   // R7: no strobe without a chip select
   p_strobe_in_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_oe_n || !mem_we_n || !(&mem_lane_n)) |-> !(&mem_cs_n));

   // R13: at most one chip select active
   p_one_cs_r13: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~mem_cs_n));

   // R13: address steady while a chip select stays low
   p_addr_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (!(&mem_cs_n) && $past(!(&mem_cs_n))) |-> $stable(mem_addr));

   // R10: address held across the chip-select release of a slow cycle
   p_slow_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(&mem_cs_n) && (state == ST_POST)) |-> $stable(mem_addr));

   // R11: nothing is driven while the bus is granted away
   p_float_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_drive |-> (!data_drive && (&mem_cs_n)));

endmodule

// File: rtl/smc_bus_ctrl.sv
module smc_bus_ctrl
   import smc_pkg::*;
#(
   parameter int ADDR_W  = 20,
   parameter int DATA_W  = 16,
   parameter int NUM_CS  = 4,
   parameter int WS_W    = 3,
   parameter int SLOW_CS = 3,
   parameter int SLOW_WS = 2,
   localparam int CS_W   = $clog2(NUM_CS),
   localparam int LANES  = DATA_W / 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   input  logic                   req_write,
   input  logic [CS_W-1:0]        req_cs,
   input  logic [ADDR_W-1:0]      req_addr,
   input  logic [DATA_W-1:0]      req_wdata,
   input  logic [LANES-1:0]       req_be,
   output logic                   busy,
   output logic                   done,
   output logic [DATA_W-1:0]      rdata,
   input  logic [NUM_CS*WS_W-1:0] cfg_ws,
   input  logic [NUM_CS-1:0]      cfg_early,
   input  logic [NUM_CS-1:0]      cfg_bytewr,
   input  logic                   cfg_slow_en,
   input  logic                   ext_req,
   output logic                   ext_gnt,
   output logic [ADDR_W-1:0]      mem_addr,
   output logic [DATA_W-1:0]      mem_dout,
   input  logic [DATA_W-1:0]      mem_din,
   output logic                   data_drive,
   output logic                   bus_drive,
   output logic [NUM_CS-1:0]      mem_cs_n,
   output logic                   mem_oe_n,
   output logic                   mem_we_n,
   output logic [LANES-1:0]       mem_lane_n
);

   if ((DATA_W % 8) != 0 || DATA_W < 8) begin : g_bad_dw
      $error("DATA_W must be a positive multiple of 8");
   end
   if (NUM_CS < 2 || NUM_CS != (1 << CS_W)) begin : g_bad_cs
      $error("NUM_CS must be a power of two, at least 2");
   end
   if (SLOW_CS >= NUM_CS) begin : g_bad_slow
      $error("SLOW_CS must name an existing chip select");
   end
   if (SLOW_WS >= (1 << WS_W)) begin : g_bad_sws
      $error("SLOW_WS must fit in WS_W bits");
   end

   logic [WS_W-1:0]   sel_ws;
   smc_mode_t         sel_mode;
   smc_state_e        state;
   logic              last_strobe;
   logic              lat_write;
   logic [CS_W-1:0]   lat_cs;
   logic [ADDR_W-1:0] lat_addr;
   logic [DATA_W-1:0] lat_wdata;
   logic [LANES-1:0]  lat_be;
   smc_mode_t         lat_mode;

   smc_cfg_sel #(.NUM_CS(NUM_CS), .WS_W(WS_W), .SLOW_CS(SLOW_CS)) u_cfg (
      .cfg_ws     (cfg_ws),
      .cfg_early  (cfg_early),
      .cfg_bytewr (cfg_bytewr),
      .cfg_slow_en(cfg_slow_en),
      .sel_cs     (req_cs),
      .sel_ws     (sel_ws),
      .sel_mode   (sel_mode)
   );

   smc_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CS(NUM_CS), .WS_W(WS_W),
             .SLOW_WS(SLOW_WS)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_write  (req_write),
      .req_cs     (req_cs),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .req_be     (req_be),
      .sel_ws     (sel_ws),
      .sel_mode   (sel_mode),
      .ext_req    (ext_req),
      .state      (state),
      .last_strobe(last_strobe),
      .lat_write  (lat_write),
      .lat_cs     (lat_cs),
      .lat_addr   (lat_addr),
      .lat_wdata  (lat_wdata),
      .lat_be     (lat_be),
      .lat_mode   (lat_mode),
      .busy       (busy),
      .done       (done),
      .gnt        (ext_gnt)
   );

   smc_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CS(NUM_CS)) u_pins (
      .clk        (clk),
      .rst_n      (rst_n),
      .state      (state),
      .last_strobe(last_strobe),
      .lat_write  (lat_write),
      .lat_cs     (lat_cs),
      .lat_addr   (lat_addr),
      .lat_wdata  (lat_wdata),
      .lat_be     (lat_be),
      .lat_mode   (lat_mode),
      .mem_din    (mem_din),
      .mem_addr   (mem_addr),
      .mem_dout   (mem_dout),
      .data_drive (data_drive),
      .bus_drive  (bus_drive),
      .mem_cs_n   (mem_cs_n),
      .mem_oe_n   (mem_oe_n),
      .mem_we_n   (mem_we_n),
      .mem_lane_n (mem_lane_n),
      .rdata      (rdata)
   );

endmodule

// File: tb/sim_smc_bus_ctrl.sv
module sim_smc_bus_ctrl;

   localparam int AW = 20, DW = 16, NCS = 4, WSW = 3;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [1:0] req_cs = '0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [1:0] req_be = '0;
   logic busy, done, ext_gnt, data_drive, bus_drive, mem_oe_n, mem_we_n;
   logic [DW-1:0] rdata, mem_dout, mem_din;
   logic [AW-1:0] mem_addr;
   logic [NCS*WSW-1:0] cfg_ws = '0;
   logic [NCS-1:0] cfg_early = '0, cfg_bytewr = '0, mem_cs_n;
   logic cfg_slow_en = 1'b0, ext_req = 1'b0;
   logic [1:0] mem_lane_n;

   smc_bus_ctrl u0 (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_cs(req_cs), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .busy(busy), .done(done), .rdata(rdata), .cfg_ws(cfg_ws), .cfg_early(cfg_early),
      .cfg_bytewr(cfg_bytewr), .cfg_slow_en(cfg_slow_en), .ext_req(ext_req),
      .ext_gnt(ext_gnt), .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_din(mem_din),
      .data_drive(data_drive), .bus_drive(bus_drive), .mem_cs_n(mem_cs_n),
      .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_lane_n(mem_lane_n));

   always #10 clk = ~clk;

   assign mem_din = !mem_oe_n ? (mem_addr[15:0] ^ 16'hA55A) : 16'h0000;

   typedef struct {
      int t_done, first_cs, n_cs, n_oe, n_we, n_l0, n_l1, n_dd, cs;
      bit rd;
      logic [AW-1:0] addr;
      logic [DW-1:0] wdata, rdata;
   } exp_t;

   exp_t q[$];
   exp_t cur;
   int vectors = 0, miscompares = 0, cyc = 0;
   int tb_ws[4];
   bit tb_early[4], tb_bytewr[4], tb_slow;
   bit mon_on = 0, prev_busy = 0;
   int t, m_first, m_cs, m_oe, m_we, m_l0, m_l1, m_dd, m_csbad, m_abad, m_dbad;

   task automatic chk(input string rq, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   task automatic set_cfg();
      for (int i = 0; i < 4; i++) begin
         cfg_ws[i*WSW +: WSW] = 3'(tb_ws[i]);
         cfg_early[i]  = tb_early[i];
         cfg_bytewr[i] = tb_bytewr[i];
      end
      cfg_slow_en = tb_slow;
   endtask

   // driver: computes the expected pin behaviour from the requirements and queues it
   task automatic access(input bit wr, input int cs, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input logic [1:0] be);
      exp_t e;
      bit sl = tb_slow && (cs == 3);
      int w = sl ? 2 : tb_ws[cs];
      e.t_done   = w + 4 + (sl ? 2 : 0);
      e.first_cs = sl ? 2 : 1;
      e.n_cs     = 3 + w;
      e.n_oe     = wr ? 0 : (tb_early[cs] ? 2 + w : 1 + w);
      if (!tb_bytewr[cs]) begin
         e.n_we = wr ? 1 + w : 0;
         e.n_l0 = be[0] ? 3 + w : 0;
         e.n_l1 = be[1] ? 3 + w : 0;
      end else begin
         e.n_we = 0;
         e.n_l0 = (wr && be[0]) ? 1 + w : 0;
         e.n_l1 = (wr && be[1]) ? 1 + w : 0;
      end
      e.n_dd  = wr ? (sl ? 5 + w : 3 + w) : 0;
      e.cs    = cs;
      e.rd    = !wr;
      e.addr  = a;
      e.wdata = d;
      e.rdata = a[15:0] ^ 16'hA55A;
      q.push_back(e);
      @(negedge clk);
      req_write = wr; req_cs = 2'(cs); req_addr = a; req_wdata = d; req_be = be;
      req_valid = 1'b1;
      @(negedge clk);
      while (!busy) @(negedge clk);
      req_valid = 1'b0;
      while (busy) @(negedge clk);
   endtask

   // monitor: counts pin activity per access and compares at the done pulse
   always @(negedge clk) begin
      if (mon_on) begin
         if (busy) begin
            if (!prev_busy) begin
               t = 1; m_first = 0; m_cs = 0; m_oe = 0; m_we = 0; m_l0 = 0; m_l1 = 0;
               m_dd = 0; m_csbad = 0; m_abad = 0; m_dbad = 0;
            end else t++;
            if (!(&mem_cs_n)) begin
               m_cs++;
               if (m_first == 0) m_first = t;
               if (q.size() > 0 && (~mem_cs_n) != 4'(1 << q[0].cs)) m_csbad++;
            end
            if (q.size() > 0 && mem_addr != q[0].addr) m_abad++;
            if (!mem_oe_n) m_oe++;
            if (!mem_we_n) m_we++;
            if (!mem_lane_n[0]) m_l0++;
            if (!mem_lane_n[1]) m_l1++;
            if (data_drive) begin
               m_dd++;
               if (q.size() > 0 && mem_dout != q[0].wdata) m_dbad++;
            end
            if (done) begin
               if (q.size() == 0) chk("R2 unexpected done", 1, 0);
               else begin
                  cur = q.pop_front();
                  chk("R2/R3/R10 done cycle", t, cur.t_done);
                  chk("R2/R3 chip select low cycles", m_cs, cur.n_cs);
                  chk("R10 first chip select cycle", m_first, cur.first_cs);
                  chk("R4 output enable low cycles", m_oe, cur.n_oe);
                  chk("R5/R6 write strobe low cycles", m_we, cur.n_we);
                  chk("R5/R6 lane0 low cycles", m_l0, cur.n_l0);
                  chk("R5/R6 lane1 low cycles", m_l1, cur.n_l1);
                  chk("R9/R10 data drive cycles", m_dd, cur.n_dd);
                  chk("R9 write data mismatches", m_dbad, 0);
                  chk("R13 wrong chip select", m_csbad, 0);
                  chk("R13 address mismatches", m_abad, 0);
                  if (cur.rd) chk("R8 read data", int'(rdata), int'(cur.rdata));
               end
            end
         end else if (done) chk("R2 done without busy", 1, 0);
         prev_busy = busy;
      end
   end

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000) begin
         chk("watchdog expired", 1, 0);
         finish_run();
      end
   end

   initial begin
      tb_ws = '{0, 3, 1, 5};
      tb_early = '{0, 1, 1, 0};
      tb_bytewr = '{0, 1, 0, 1};
      tb_slow = 1;
      set_cfg();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 chip selects", int'(mem_cs_n), 15);
      chk("R1 oe/we", int'({mem_oe_n, mem_we_n}), 3);
      chk("R1 lanes", int'(mem_lane_n), 3);
      chk("R1 busy/done/gnt", int'({busy, done, ext_gnt}), 0);
      chk("R1 drives", int'({bus_drive, data_drive}), 2);
      mon_on = 1;

      access(1, 0, 20'h01234, 16'hBEEF, 2'b11);  // R2 zero-wait write, byte-select
      access(0, 0, 20'h01234, 16'h0,    2'b11);  // R2 zero-wait standard read
      access(1, 0, 20'h00102, 16'h1357, 2'b01);  // R5 one lane
      access(0, 1, 20'h0A0A0, 16'h0,    2'b11);  // R4 early, R6 read lanes high
      access(1, 1, 20'h0A0A2, 16'h2468, 2'b10);  // R6 byte-write lane
      access(0, 2, 20'h0F00F, 16'h0,    2'b10);  // R4 early byte-select read
      access(1, 2, 20'h0F010, 16'hCAFE, 2'b10);  // R5
      access(1, 3, 20'h33330, 16'hABCD, 2'b11);  // R10 slow write (ws forced 2)
      access(0, 3, 20'h33332, 16'h0,    2'b11);  // R10 slow read
      tb_slow = 0; set_cfg();
      access(1, 3, 20'h44440, 16'h5555, 2'b01);  // R3 ws5 normal on cs3
      access(0, 3, 20'h44442, 16'h0,    2'b11);
      tb_ws[0] = 7; set_cfg();
      access(0, 0, 20'h7FFFE, 16'h0,    2'b11);  // R3 max wait states
      access(1, 0, 20'h7FFFC, 16'h9999, 2'b11);
      // R8 rdata holds through a write
      chk("R8 rdata held after write", int'(rdata), int'(16'hFFFE ^ 16'hA55A));

      // R11 grant refused during an access, given after it
      fork access(0, 0, 20'h12345, 16'h0, 2'b11); join_none
      repeat (3) @(negedge clk);
      ext_req = 1'b1;
      @(negedge clk);
      chk("R11 no grant while busy", int'(ext_gnt), 0);
      wait fork;
      @(negedge clk);
      chk("R11 grant given", int'(ext_gnt), 1);
      chk("R11 bus released", int'(bus_drive), 0);
      chk("R11 data released", int'(data_drive), 0);
      // R12 request stalls while granted
      fork access(1, 2, 20'h0ABCD, 16'h7E7E, 2'b11); join_none
      repeat (5) @(negedge clk);
      chk("R12 busy stays low", int'(busy), 0);
      chk("R12 chip selects high", int'(mem_cs_n), 15);
      ext_req = 1'b0;
      @(negedge clk);
      chk("R11 grant removed", int'(ext_gnt), 0);
      chk("R11 bus driven again", int'(bus_drive), 1);
      wait fork;
      repeat (3) @(negedge clk);
      chk("R2 all expected results seen", q.size(), 0);
      finish_run();
   end

endmodule